// File: doc/BRIEF.md
# Windowed Watchdog Timer with Key Restart

This block supervises a host by requiring it to service the timer inside a programmable window. The window has a leading edge (the earliest moment a service is accepted) and a trailing edge (the latest moment), each given as a 5-bit code counted in prescaler ticks, where one tick stands for a 25 ms step, so each edge spans 0 to 775 ms. The host services the timer by writing a 4-bit key; only the value 1010b counts as a restart. Any other value is discarded.

Window codes are written into shadow registers at any time. They become active only when a valid key restart occurs, so a host can never shift the window it is currently being judged against. A restart before the leading edge is an early fault. Reaching the trailing edge with no restart is a late fault. Each fault sets its own sticky flag, and when the enable input is high it also raises a reset request for a fixed number of clocks. With the enable low, the timer still runs and still flags faults but never requests a reset.

Top module: `wdw_top`

## Requirements
- R1: After reset, rst_req is 0, both fault flags are 0, the active leading code is 0 and the active trailing code is 31.
- R2: A write of new window codes has no effect on the running interval; the fault timing stays that of the active codes until the next valid key restart.
- R3: Writing key value 1010b (key_val[3:0]) with key_we restarts the count from zero in the next cycle and loads the shadow window codes into the active window.
- R4: Any key value other than 1010b is ignored: it neither restarts the count nor loads the codes.
- R5: With leading code below trailing code, a valid key restart when fewer than leading-code ticks have elapsed since the last restart sets flag_early in the next cycle.
- R6: When trailing-code ticks have elapsed since the last restart with no valid key in that cycle, flag_late is set in the next cycle and the count restarts from zero with the active codes; cycles with tick low do not advance the count.
- R7: When the leading code is not less than the trailing code, no key restart ever raises flag_early.
- R8: With wdt_en at 1, a fault raises rst_req in the next cycle and holds it for exactly PULSE_CLKS clocks (default 4).
- R9: With wdt_en at 0, a fault sets its flag but rst_req stays 0.
- R10: Flags are sticky; flag_we with flag_wdata bit 0 (early) or bit 1 (late) at 0 clears that flag, a 1 leaves it unchanged, and a fault in the same cycle as a clear leaves the flag set.
- R11: While rst_req is high the count is held at zero and key writes are ignored; counting resumes from zero in the first cycle after rst_req falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle step pulse from the prescaler (one 25 ms step) |
| wdt_en | input | 1 | 1 lets a fault drive rst_req |
| cfg_we | input | 1 | Write strobe for the shadow window codes |
| cfg_lead | input | 5 | Leading-edge code in steps |
| cfg_trail | input | 5 | Trailing-edge code in steps |
| key_we | input | 1 | Write strobe for the restart key |
| key_val | input | 4 | Restart key; only 1010b restarts |
| flag_we | input | 1 | Write strobe for the fault flags |
| flag_wdata | input | 2 | Bit 0 early, bit 1 late; 0 clears, 1 keeps |
| rst_req | output | 1 | Reset request pulse |
| flag_early | output | 1 | Sticky early-service fault flag |
| flag_late | output | 1 | Sticky missed-service fault flag |

## Verification
Every cycle, the checker confirms that the count never passes the active trailing code and sits at zero during a reset pulse, that the active window moves only on an accepted restart, that a reset pulse rises only with the enable set and lasts exactly the configured length, and that the flags stay set unless cleared and an early flag rises only after a valid key. The bench sweeps leading and trailing codes against every service time up to one step past the trailing edge, which is where the exact boundary of the window, the degenerate window with leading not below trailing, and the effect of stale shadow writes and of wrong key values become visible. Pulse handling, keys arriving during a pulse and the clear-versus-set race are covered by directed scenarios.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned KEY_W  = 4;
  localparam logic [KEY_W-1:0] RESTART_KEY = 4'b1010;

  typedef struct packed {
    logic [CODE_W-1:0] lead;
    logic [CODE_W-1:0] trail;
  } wdw_window_t;

  typedef enum logic [1:0] {
    FAULT_NONE  = 2'd0,
    FAULT_EARLY = 2'd1,
    FAULT_LATE  = 2'd2
  } wdw_fault_e;
endpackage

// File: rtl/wdw_window_regs.sv
module wdw_window_regs
  import wdw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  wdw_window_t cfg_win,
  input  logic        load,
  output wdw_window_t act_win
);
  wdw_window_t shadow_q, shadow_d;
  wdw_window_t active_q, active_d;

  always_comb begin
    shadow_d = shadow_q;
    if (cfg_we) shadow_d = cfg_win;
  end

  always_comb begin
    active_d = active_q;
    if (load) active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '{lead: '0, trail: '1};
      active_q <= '{lead: '0, trail: '1};
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign act_win = active_q;
endmodule

// File: rtl/wdw_timer.sv
module wdw_timer
  import wdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold,
  input  logic              key_ok,
  input  wdw_window_t       act_win,
  output wdw_fault_e        fault,
  output logic              restart,
  output logic [CODE_W-1:0] count
);
  logic [CODE_W-1:0] count_q, count_d;
  logic [CODE_W-1:0] eff_lead;
  logic              early, late;

  // A degenerate window keeps only its trailing edge.
  assign eff_lead = (act_win.lead < act_win.trail) ? act_win.lead : '0;

  always_comb begin
    restart = key_ok && !hold;
    early   = restart && (count_q < eff_lead);
    late    = !hold && !restart && (count_q >= act_win.trail);
    if (early)     fault = FAULT_EARLY;
    else if (late) fault = FAULT_LATE;
    else           fault = FAULT_NONE;
  end

  always_comb begin
    count_d = count_q;
    if (hold || restart || late) count_d = '0;
    else if (tick)               count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/wdw_pulse.sv
module wdw_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire)            cnt_d = LEN_V;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/wdw_top.sv
module wdw_top
  import wdw_pkg::*;
#(
  parameter int unsigned PULSE_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wdt_en,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_lead,
  input  logic [CODE_W-1:0] cfg_trail,
  input  logic              key_we,
  input  logic [KEY_W-1:0]  key_val,
  input  logic              flag_we,
  input  logic [1:0]        flag_wdata,
  output logic              rst_req,
  output logic              flag_early,
  output logic              flag_late
);
  logic [1:0]        rsync_q;
  logic              rst_int_n;
  wdw_window_t       cfg_win, act_win;
  wdw_fault_e        fault;
  logic              restart, key_ok, fire, pulse_on;
  logic [CODE_W-1:0] count;
  logic              early_q, early_d, late_q, late_d;

  // Reset asserts at once and releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign cfg_win = '{lead: cfg_lead, trail: cfg_trail};
  assign key_ok  = key_we && (key_val == RESTART_KEY);

  wdw_window_regs u_win (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cfg_we  (cfg_we),
    .cfg_win (cfg_win),
    .load    (restart),
    .act_win (act_win)
  );

  wdw_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .hold    (pulse_on),
    .key_ok  (key_ok),
    .act_win (act_win),
    .fault   (fault),
    .restart (restart),
    .count   (count)
  );

  assign fire = wdt_en && (fault != FAULT_NONE);

  wdw_pulse #(.LEN(PULSE_CLKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .fire   (fire),
    .active (pulse_on)
  );

  always_comb begin
    early_d = early_q;
    late_d  = late_q;
    if (flag_we && !flag_wdata[0]) early_d = 1'b0;
    if (flag_we && !flag_wdata[1]) late_d  = 1'b0;
    if (fault == FAULT_EARLY)      early_d = 1'b1;
    if (fault == FAULT_LATE)       late_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      early_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      early_q <= early_d;
      late_q  <= late_d;
    end
  end

  assign rst_req    = pulse_on;
  assign flag_early = early_q;
  assign flag_late  = late_q;
endmodule

// File: rtl/wdw_checker.sv
module wdw_checker
  import wdw_pkg::*;
#(
  parameter int unsigned PULSE_CLKS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_en,
  input logic              key_we,
  input logic [KEY_W-1:0]  key_val,
  input logic              flag_we,
  input logic [1:0]        flag_wdata,
  input logic              rst_req,
  input logic              flag_early,
  input logic              flag_late,
  input logic [CODE_W-1:0] count,
  input logic              restart,
  input wdw_window_t       act_win
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (rst_req) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  AST_COUNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= act_win.trail); // R6

  AST_WINDOW_LOADS_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(act_win)); // R2

  AST_HOLD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> count == '0); // R11

  AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(wdt_en)); // R9

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> run_q == 16'(PULSE_CLKS)); // R8

  AST_EARLY_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_early) |-> $past(key_we && key_val == RESTART_KEY)); // R5

  AST_EARLY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_early && !(flag_we && !flag_wdata[0]) |=> flag_early); // R10

  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_late && !(flag_we && !flag_wdata[1]) |=> flag_late); // R10
endmodule

bind wdw_top wdw_checker #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wdt_en     (wdt_en),
  .key_we     (key_we),
  .key_val    (key_val),
  .flag_we    (flag_we),
  .flag_wdata (flag_wdata),
  .rst_req    (rst_req),
  .flag_early (flag_early),
  .flag_late  (flag_late),
  .count      (count),
  .restart    (restart),
  .act_win    (act_win)
);

// File: tb/test_wdw_top.sv
module test_wdw_top;
  localparam int P = 4;
  localparam logic [3:0] KEY = 4'b1010;

  logic       clk = 1'b0;
  logic       rst_n, tick, wdt_en, cfg_we, key_we, flag_we;
  logic [4:0] cfg_lead, cfg_trail;
  logic [3:0] key_val;
  logic [1:0] flag_wdata;
  logic       rst_req, flag_early, flag_late;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdw_top #(.PULSE_CLKS(P)) i_wdw_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wdt_en(wdt_en),
    .cfg_we(cfg_we), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail),
    .key_we(key_we), .key_val(key_val),
    .flag_we(flag_we), .flag_wdata(flag_wdata),
    .rst_req(rst_req), .flag_early(flag_early), .flag_late(flag_late)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a sample point; returns one cycle later.
  task automatic key(logic [3:0] v);
    key_we = 1'b1; key_val = v;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  // Loads window (s,e), then restarts in window with flags cleared.
  // Returns at the first cycle of a fresh interval.
  task automatic arm(int s, int e);
    cfg_we = 1'b1; cfg_lead = 5'(s); cfg_trail = 5'(e);
    @(negedge clk);
    cfg_we = 1'b0;
    key(KEY);
    flag_we = 1'b1; flag_wdata = 2'b00;
    if (e == 0) begin key_we = 1'b1; key_val = KEY; end
    @(negedge clk);
    flag_we = 1'b0; key_we = 1'b0;
    if (e > 0) begin
      cyc(e - 1);
      key(KEY);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int codes[7] = '{0, 1, 2, 3, 5, 7, 31};
    rst_n = 1'b0; tick = 1'b1; wdt_en = 1'b0; cfg_we = 1'b0; key_we = 1'b0;
    flag_we = 1'b0; cfg_lead = '0; cfg_trail = '0; key_val = '0; flag_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 rst_req", int'(rst_req), 0);
    chk("R1 flag_early", int'(flag_early), 0);
    chk("R1 flag_late", int'(flag_late), 0);
    cyc(20);
    chk("R1 default trailing code 31", int'(flag_late), 0);
    key(KEY);
    chk("R1 default leading code 0", int'(flag_early), 0);

    // Window sweep with reset output disabled
    foreach (codes[a]) begin
      foreach (codes[b]) begin
        int s = codes[a];
        int e = codes[b];
        int eff = (s < e) ? s : 0;
        for (int k = 0; k <= e + 1; k++) begin
          arm(s, e);
          if (k <= e) begin
            cyc(k);
            key(KEY);
            if (s >= e) chk("R7 degenerate window no early", int'(flag_early), 0);
            else        chk("R5 early at service time", int'(flag_early), int'(k < eff));
            chk("R3 in-time restart no late", int'(flag_late), 0);
          end else begin
            cyc(e);
            chk("R6 late not before trailing edge", int'(flag_late), 0);
            cyc(1);
            chk("R6 late at trailing edge", int'(flag_late), 1);
            chk("R6 late only", int'(flag_early), 0);
          end
          chk("R9 no reset request when disabled", int'(rst_req), 0);
        end
      end
    end

    // R2: shadow write without key does not move the running window
    arm(0, 3);
    cfg_we = 1'b1; cfg_lead = 5'd0; cfg_trail = 5'd10;
    @(negedge clk);
    cfg_we = 1'b0;
    cyc(2);
    chk("R2 old trailing edge still pending", int'(flag_late), 0);
    cyc(1);
    chk("R2 late at old trailing edge", int'(flag_late), 1);

    // R4: wrong key values are ignored
    for (int v = 0; v < 16; v++) begin
      if (v == 10) continue;
      arm(0, 3);
      cyc(1);
      key(4'(v));
      cyc(1);
      chk("R4 wrong key no restart before edge", int'(flag_late), 0);
      cyc(1);
      chk("R4 wrong key late at original edge", int'(flag_late), 1);
    end

    // R6: tick low freezes the count
    arm(0, 2);
    tick = 1'b0;
    cyc(10);
    chk("R6 no progress without tick", int'(flag_late), 0);
    tick = 1'b1;
    cyc(2);
    chk("R6 late pending after tick resumes", int'(flag_late), 0);
    cyc(1);
    chk("R6 late after two ticks", int'(flag_late), 1);

    // R8/R11: reset pulse, keys during pulse, restart after pulse
    arm(2, 4);
    wdt_en = 1'b1;
    cyc(4);
    chk("R8 no pulse before fault", int'(rst_req), 0);
    cyc(1);
    chk("R8 pulse after late fault", int'(rst_req), 1);
    key(KEY);
    chk("R8 pulse cycle 2", int'(rst_req), 1);
    chk("R11 key during pulse ignored", int'(flag_early), 0);
    cyc(1);
    chk("R8 pulse cycle 3", int'(rst_req), 1);
    cyc(1);
    chk("R8 pulse cycle 4", int'(rst_req), 1);
    cyc(1);
    chk("R8 pulse ends after PULSE_CLKS", int'(rst_req), 0);
    cyc(4);
    chk("R11 counting from zero after pulse", int'(rst_req), 0);
    cyc(1);
    chk("R11 next late fault after pulse", int'(rst_req), 1);
    cyc(P);
    chk("R8 second pulse ends", int'(rst_req), 0);
    key(KEY);
    chk("R8 early fault flag", int'(flag_early), 1);
    chk("R8 early fault pulse", int'(rst_req), 1);
    cyc(P);
    chk("R8 early pulse ends", int'(rst_req), 0);
    wdt_en = 1'b0;

    // R10: flag write semantics
    arm(0, 31);
    arm(3, 31);
    key(KEY);
    chk("R10 early set", int'(flag_early), 1);
    flag_we = 1'b1; flag_wdata = 2'b11;
    @(negedge clk);
    flag_we = 1'b0;
    chk("R10 writing 1 keeps early", int'(flag_early), 1);
    flag_we = 1'b1; flag_wdata = 2'b10;
    @(negedge clk);
    flag_we = 1'b0;
    chk("R10 writing 0 clears early", int'(flag_early), 0);
    key(KEY);
    chk("R10 early set again", int'(flag_early), 1);
    flag_we = 1'b1; flag_wdata = 2'b00; key_we = 1'b1; key_val = KEY;
    @(negedge clk);
    flag_we = 1'b0; key_we = 1'b0;
    chk("R10 set wins over clear", int'(flag_early), 1);
    chk("R10 late untouched", int'(flag_late), 0);

    report();
  end
endmodule